// File: doc/BRIEF.md
# ATAPI Device Task-File Controller

This block is the device-side register file and transfer sequencer of an ATA packet interface, as seen by a host. The host reads and writes a small set of task-file registers through single-cycle strobes: error/feature, interrupt reason, a sector byte, byte-count low and high, status/command and alternate-status/control. It also moves 16-bit words through a data port. The block runs the state machine that collects a 12-byte command packet and paces programmed-I/O transfers. It raises and clears the device interrupt and applies the host's interrupt-enable mask.

The back end sees three interfaces. The first is a word-addressed buffer port: reads are combinational, and writes are strobed. The second is a valid/ready packet stream that carries the 12 collected bytes. `pkt_valid` rises after the sixth command word and stays high, with `pkt_data` held stable, until a cycle in which `pkt_ready` is high. The third is a valid/ready transfer request that starts a read or write of N bytes, in PIO or DMA mode. `xfer_ready` is high only when the block is idle or busy, no packet is waiting and the host is not writing a command in that cycle. A request offered while `xfer_ready` is low must be held. `dma_done` ends a DMA-mode transfer. Decoding packet contents and moving DMA data happen outside this block.

Top module: `atapi_taskfile_ctrl`

## Requirements
- R1: Register offsets on `hst_addr` are 0 data, 1 error (read) / feature (write), 2 interrupt reason, 3 sector byte, 4 byte-count low, 5 byte-count high, 7 status (read) / command (write), 14 alternate status (read) / control (write). Reset leaves these values: error 0x01, reason 0x01, sector 0x81, byte-count low 0x14, byte-count high 0xEB, status 0x00, interrupt low, no packet pending.
- R2: Command 0xA0 enters packet collection. Status becomes 0x58, reason becomes 0x01 and error becomes feature[1:0]. No interrupt is raised.
- R3: The sixth data-port write during collection makes status 0xD0 and raises `pkt_valid`. Word k of the packet is on `pkt_data[16k+15:16k]`. Valid and data stay unchanged until `pkt_ready` is sampled high.
- R4: An accepted PIO request of N>0 bytes has these effects. Status becomes 0x58. Byte-count low/high become N[7:0]/N[15:8]. Reason becomes 0x02 for a read and 0x00 for a write. The interrupt is raised. `xfer_ready` is low during a PIO transfer and while a packet waits.
- R5: An accepted DMA request of N>0 bytes sets status 0xD0 and reason as in R4, and does not raise the interrupt. `dma_done` in that state returns to idle with status 0x50 and reason 0x03, and raises the interrupt.
- R6: Each data-port access in a PIO transfer advances the byte offset by 2. `buf_addr` is the offset divided by 2, and a PIO write drives `buf_we` with the host word. When the offset reaches or passes N (odd N included), the block goes idle with status 0x50 and reason 0x03 and raises the interrupt.
- R7: A data-port read outside a PIO read returns 0xFFFF and changes no state.
- R8: A status read (offset 7) clears the pending interrupt only when status bit 7 (BSY) is 0. An alternate-status read never clears it.
- R9: `irq` is the pending flag masked by control bit 1. Writing 1 there hides a pending interrupt, and writing 0 shows it again.
- R10: Every command write clears the pending interrupt. Command 0x00 aborts any state: idle, status 0x51, error 0x04, packet dropped, interrupt raised.
- R11: Command 0xEF sets status 0x50, error 0x00 and byte-count low/high 0x00, and raises the interrupt.
- R12: Command 0x08 restores every R1 reset value. Any command other than 0x00, 0x08, 0xA0 or 0xEF only clears the pending interrupt.
- R13: An accepted request with N=0 completes at once. The block goes idle with status 0x50 and reason 0x03 and raises the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_wr | input | 1 | Host register write strobe |
| hst_rd | input | 1 | Host register read strobe |
| hst_addr | input | 4 | Host register offset |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Host read data (combinational) |
| irq | output | 1 | Device interrupt |
| buf_addr | output | LEN_W-1 | Buffer word address |
| buf_we | output | 1 | Buffer write strobe |
| buf_wdata | output | 16 | Buffer write word |
| buf_rdata | input | 16 | Buffer read word |
| pkt_valid | output | 1 | Packet stream valid |
| pkt_ready | input | 1 | Packet stream ready |
| pkt_data | output | 16*PKT_WORDS | Collected packet |
| xfer_valid | input | 1 | Transfer request valid |
| xfer_ready | output | 1 | Transfer request ready |
| xfer_write | input | 1 | 1 = host writes data, 0 = host reads |
| xfer_dma | input | 1 | 1 = DMA-mode transfer |
| xfer_len | input | LEN_W | Transfer length in bytes |
| dma_done | input | 1 | End of DMA-mode transfer |

## Verification
Register, status, reason and pending-flag updates land on the clock edge that samples the strobe or handshake. `irq` follows the pending flag combinationally, so both are due one edge after the stimulus. Read data and the buffer write strobe are combinational and are due in the same cycle as the host strobe. Inputs are driven at the falling edge. Read data and buffer strobes are captured shortly after that edge, before the rising edge. Register effects are checked at the next falling edge, which is the first one after the edge that commits them.

// File: rtl/atapi_tf_pkg.sv
`timescale 1ns/1ps
package atapi_tf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CMDW, ST_BUSY, ST_PIORD, ST_PIOWR, ST_DMA
  } xstate_t;

  localparam logic [3:0] A_DATA   = 4'd0;
  localparam logic [3:0] A_ERR    = 4'd1;
  localparam logic [3:0] A_REASON = 4'd2;
  localparam logic [3:0] A_SECT   = 4'd3;
  localparam logic [3:0] A_BCL    = 4'd4;
  localparam logic [3:0] A_BCH    = 4'd5;
  localparam logic [3:0] A_STAT   = 4'd7;
  localparam logic [3:0] A_CTRL   = 4'd14;

  localparam logic [7:0] CMD_NOP     = 8'h00;
  localparam logic [7:0] CMD_DEVRST  = 8'h08;
  localparam logic [7:0] CMD_PACKET  = 8'hA0;
  localparam logic [7:0] CMD_SETFEAT = 8'hEF;

  localparam logic [7:0] STV_XFER  = 8'h58;
  localparam logic [7:0] STV_BUSY  = 8'hD0;
  localparam logic [7:0] STV_DONE  = 8'h50;
  localparam logic [7:0] STV_ABORT = 8'h51;
  localparam logic [7:0] STB_DRQ   = 8'h08;
  localparam int         STB_BSY_POS = 7;

  localparam logic [7:0] RSN_COD  = 8'h01;
  localparam logic [7:0] RSN_IO   = 8'h02;
  localparam logic [7:0] RSN_DONE = 8'h03;

  localparam logic [7:0] RST_ERR  = 8'h01;
  localparam logic [7:0] RST_RSN  = 8'h01;
  localparam logic [7:0] RST_SECT = 8'h81;
  localparam logic [7:0] RST_BCL  = 8'h14;
  localparam logic [7:0] RST_BCH  = 8'hEB;
  localparam logic [7:0] RST_STAT = 8'h00;
endpackage

// File: rtl/atapi_tf_irq.sv
`timescale 1ns/1ps
module atapi_tf_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic raise,
  input  logic clear,
  input  logic ctrl_we,
  input  logic ctrl_mask,
  output logic pending,
  output logic irq
);
  logic mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      mask_q  <= 1'b0;
    end else begin
      // a raise in the same cycle as a clear wins
      if (raise)      pending <= 1'b1;
      else if (clear) pending <= 1'b0;
      if (ctrl_we)    mask_q  <= ctrl_mask;
    end
  end

  assign irq = pending & ~mask_q;
endmodule

// File: rtl/atapi_tf_pktbuf.sv
`timescale 1ns/1ps
module atapi_tf_pktbuf #(
  parameter int WORDS = 6,
  parameter int IDX_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [IDX_W-1:0]      idx,
  input  logic [15:0]           wdata,
  output logic [WORDS*16-1:0]   pkt
);
  logic [15:0] word_q [WORDS];

  for (genvar k = 0; k < WORDS; k++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)
        word_q[k] <= '0;
      else if (we && idx == IDX_W'(k))
        word_q[k] <= wdata;
    end
    assign pkt[k*16 +: 16] = word_q[k];
  end
endmodule

// File: rtl/atapi_tf_core.sv
`timescale 1ns/1ps
module atapi_tf_core
  import atapi_tf_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int PKT_WORDS = 6,
  parameter int IDX_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_wr,
  input  logic              hst_rd,
  input  logic [3:0]        hst_addr,
  input  logic [15:0]       hst_wdata,
  output logic [15:0]       hst_rdata,
  output logic [LEN_W-2:0]  buf_addr,
  output logic              buf_we,
  output logic [15:0]       buf_wdata,
  input  logic [15:0]       buf_rdata,
  output logic              pkt_we,
  output logic [IDX_W-1:0]  pkt_idx,
  output logic              pkt_valid,
  input  logic              pkt_ready,
  input  logic              xfer_valid,
  output logic              xfer_ready,
  input  logic              xfer_write,
  input  logic              xfer_dma,
  input  logic [LEN_W-1:0]  xfer_len,
  input  logic              dma_done,
  output logic              irq_raise,
  output logic              irq_clear,
  output logic [7:0]        stat_o
);
  localparam int PKT_BYTES = 2 * PKT_WORDS;

  xstate_t          state_q;
  logic [7:0]       stat_q, err_q, rsn_q, sect_q, bcl_q, bch_q;
  logic [1:0]       feat_q;
  logic [LEN_W-2:0] wcnt_q;
  logic [LEN_W-1:0] len_q;
  logic             pktv_q;

  logic wr_cmd, wr_feat, wr_data, rd_data, rd_stat;
  logic cmd_word, pio_rd_go, pio_wr_go, dma_end, xfer_go;
  logic [LEN_W:0] byte_next;
  logic xfer_last, pkt_last;
  logic [15:0] len16;

  assign wr_cmd  = hst_wr && (hst_addr == A_STAT);
  assign wr_feat = hst_wr && (hst_addr == A_ERR);
  assign wr_data = hst_wr && (hst_addr == A_DATA);
  assign rd_data = hst_rd && (hst_addr == A_DATA);
  assign rd_stat = hst_rd && (hst_addr == A_STAT);

  assign cmd_word  = wr_data && (state_q == ST_CMDW);
  assign pio_wr_go = wr_data && (state_q == ST_PIOWR);
  assign pio_rd_go = rd_data && (state_q == ST_PIORD) && !wr_cmd;
  assign dma_end   = dma_done && (state_q == ST_DMA) && !wr_cmd;

  assign xfer_ready = ((state_q == ST_IDLE) || (state_q == ST_BUSY)) && !pktv_q && !wr_cmd;
  assign xfer_go    = xfer_valid && xfer_ready;
  assign len16      = 16'(xfer_len);

  // byte offset after the current word
  assign byte_next = ({2'b00, wcnt_q} + (LEN_W+1)'(1)) << 1;
  assign xfer_last = byte_next >= {1'b0, len_q};
  assign pkt_last  = byte_next >= (LEN_W+1)'(PKT_BYTES);

  assign irq_clear = wr_cmd || (rd_stat && !stat_q[STB_BSY_POS]);
  assign irq_raise = (wr_cmd && (hst_wdata[7:0] == CMD_NOP || hst_wdata[7:0] == CMD_SETFEAT))
                   || ((pio_rd_go || pio_wr_go) && xfer_last)
                   || dma_end
                   || (xfer_go && (xfer_len == '0 || !xfer_dma));

  assign buf_addr  = wcnt_q;
  assign buf_we    = pio_wr_go;
  assign buf_wdata = hst_wdata;
  assign pkt_we    = cmd_word;
  assign pkt_idx   = wcnt_q[IDX_W-1:0];
  assign pkt_valid = pktv_q;
  assign stat_o    = stat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      stat_q  <= RST_STAT;
      err_q   <= RST_ERR;
      rsn_q   <= RST_RSN;
      sect_q  <= RST_SECT;
      bcl_q   <= RST_BCL;
      bch_q   <= RST_BCH;
      feat_q  <= '0;
      wcnt_q  <= '0;
      len_q   <= '0;
      pktv_q  <= 1'b0;
    end else begin
      if (pktv_q && pkt_ready) pktv_q <= 1'b0;
      if (wr_feat) feat_q <= hst_wdata[1:0];

      if (wr_cmd) begin
        unique case (hst_wdata[7:0])
          CMD_NOP: begin
            state_q <= ST_IDLE;
            stat_q  <= STV_ABORT;
            err_q   <= 8'h04;
            pktv_q  <= 1'b0;
            wcnt_q  <= '0;
          end
          CMD_DEVRST: begin
            state_q <= ST_IDLE;
            stat_q  <= RST_STAT;
            err_q   <= RST_ERR;
            rsn_q   <= RST_RSN;
            sect_q  <= RST_SECT;
            bcl_q   <= RST_BCL;
            bch_q   <= RST_BCH;
            feat_q  <= '0;
            pktv_q  <= 1'b0;
            wcnt_q  <= '0;
          end
          CMD_PACKET: begin
            state_q <= ST_CMDW;
            stat_q  <= STV_XFER;
            err_q   <= {6'b0, feat_q};
            rsn_q   <= RSN_COD;
            wcnt_q  <= '0;
          end
          CMD_SETFEAT: begin
            stat_q  <= STV_DONE;
            err_q   <= 8'h00;
            bcl_q   <= 8'h00;
            bch_q   <= 8'h00;
          end
          default: ;
        endcase
      end else if (cmd_word) begin
        wcnt_q <= wcnt_q + 1'b1;
        if (pkt_last) begin
          state_q <= ST_BUSY;
          stat_q  <= (stat_q & ~STB_DRQ) | STV_BUSY;
          wcnt_q  <= '0;
          pktv_q  <= 1'b1;
        end
      end else if (pio_rd_go || pio_wr_go) begin
        wcnt_q <= wcnt_q + 1'b1;
        if (xfer_last) begin
          state_q <= ST_IDLE;
          stat_q  <= stat_q & ~STB_DRQ;
          rsn_q   <= RSN_DONE;
          wcnt_q  <= '0;
        end
      end else if (dma_end) begin
        state_q <= ST_IDLE;
        stat_q  <= STV_DONE;
        rsn_q   <= RSN_DONE;
      end else if (xfer_go) begin
        wcnt_q <= '0;
        len_q  <= xfer_len;
        if (xfer_len == '0) begin
          state_q <= ST_IDLE;
          stat_q  <= STV_DONE;
          rsn_q   <= RSN_DONE;
        end else if (xfer_dma) begin
          state_q <= ST_DMA;
          stat_q  <= STV_BUSY;
          rsn_q   <= xfer_write ? 8'h00 : RSN_IO;
        end else begin
          state_q <= xfer_write ? ST_PIOWR : ST_PIORD;
          stat_q  <= STV_XFER;
          rsn_q   <= xfer_write ? 8'h00 : RSN_IO;
          bcl_q   <= len16[7:0];
          bch_q   <= len16[15:8];
        end
      end
    end
  end

  always_comb begin
    hst_rdata = 16'h0000;
    unique case (hst_addr)
      A_DATA:   hst_rdata = (state_q == ST_PIORD) ? buf_rdata : 16'hFFFF;
      A_ERR:    hst_rdata = {8'h00, err_q};
      A_REASON: hst_rdata = {8'h00, rsn_q};
      A_SECT:   hst_rdata = {8'h00, sect_q};
      A_BCL:    hst_rdata = {8'h00, bcl_q};
      A_BCH:    hst_rdata = {8'h00, bch_q};
      A_STAT,
      A_CTRL:   hst_rdata = {8'h00, stat_q};
      default:  hst_rdata = 16'h0000;
    endcase
  end
endmodule

// File: rtl/atapi_taskfile_ctrl.sv
`timescale 1ns/1ps
module atapi_taskfile_ctrl
  import atapi_tf_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int PKT_WORDS = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    hst_wr,
  input  logic                    hst_rd,
  input  logic [3:0]              hst_addr,
  input  logic [15:0]             hst_wdata,
  output logic [15:0]             hst_rdata,
  output logic                    irq,
  output logic [LEN_W-2:0]        buf_addr,
  output logic                    buf_we,
  output logic [15:0]             buf_wdata,
  input  logic [15:0]             buf_rdata,
  output logic                    pkt_valid,
  input  logic                    pkt_ready,
  output logic [16*PKT_WORDS-1:0] pkt_data,
  input  logic                    xfer_valid,
  output logic                    xfer_ready,
  input  logic                    xfer_write,
  input  logic                    xfer_dma,
  input  logic [LEN_W-1:0]        xfer_len,
  input  logic                    dma_done
);
  localparam int IDX_W = (PKT_WORDS > 1) ? $clog2(PKT_WORDS) : 1;

  logic             pkt_we;
  logic [IDX_W-1:0] pkt_idx;
  logic             irq_raise, irq_clear, irq_pend, ctrl_we;
  logic [7:0]       stat_q;

  assign ctrl_we = hst_wr && (hst_addr == A_CTRL);

  atapi_tf_core #(.LEN_W(LEN_W), .PKT_WORDS(PKT_WORDS), .IDX_W(IDX_W)) u_core (
    .clk(clk), .rst_n(rst_n),
    .hst_wr(hst_wr), .hst_rd(hst_rd), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .buf_addr(buf_addr), .buf_we(buf_we), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
    .pkt_we(pkt_we), .pkt_idx(pkt_idx), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_write(xfer_write),
    .xfer_dma(xfer_dma), .xfer_len(xfer_len), .dma_done(dma_done),
    .irq_raise(irq_raise), .irq_clear(irq_clear), .stat_o(stat_q)
  );

  atapi_tf_pktbuf #(.WORDS(PKT_WORDS), .IDX_W(IDX_W)) u_pkt (
    .clk(clk), .rst_n(rst_n), .we(pkt_we), .idx(pkt_idx),
    .wdata(hst_wdata), .pkt(pkt_data)
  );

  atapi_tf_irq u_irq (
    .clk(clk), .rst_n(rst_n), .raise(irq_raise), .clear(irq_clear),
    .ctrl_we(ctrl_we), .ctrl_mask(hst_wdata[1]),
    .pending(irq_pend), .irq(irq)
  );
endmodule

// File: rtl/atapi_tf_checker.sv
`timescale 1ns/1ps
module atapi_tf_checker #(
  parameter int LEN_W = 16,
  parameter int PW    = 96
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hst_wr,
  input logic             hst_rd,
  input logic [3:0]       hst_addr,
  input logic [7:0]       cmd_byte,
  input logic             irq,
  input logic             irq_pend,
  input logic [7:0]       stat_q,
  input logic             pkt_valid,
  input logic             pkt_ready,
  input logic [PW-1:0]    pkt_data,
  input logic             xfer_valid,
  input logic             xfer_ready,
  input logic             xfer_dma,
  input logic [LEN_W-1:0] xfer_len
);
  logic cmd_wr;
  assign cmd_wr = hst_wr && (hst_addr == 4'd7);

  assert_pkt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_ready && !cmd_wr) |=> (pkt_valid && $stable(pkt_data)));

  assert_ready_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ready |-> !pkt_valid);

  assert_pio_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_ready && !xfer_dma && xfer_len != '0) |=> (stat_q == 8'h58 && irq_pend));

  assert_dma_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_ready && xfer_dma && xfer_len != '0 && !irq_pend) |=> (!irq_pend && stat_q == 8'hD0));

  assert_busy_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_rd && !hst_wr && hst_addr == 4'd7 && stat_q[7] && irq_pend) |=> irq_pend);

  assert_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_wr && hst_addr == 4'd14 && cmd_byte[1]) |=> !irq);

  assert_nop_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_byte == 8'h00) |=> (stat_q == 8'h51 && irq_pend && !pkt_valid));
endmodule

bind atapi_taskfile_ctrl atapi_tf_checker #(.LEN_W(LEN_W), .PW(16*PKT_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_rd(hst_rd), .hst_addr(hst_addr),
  .cmd_byte(hst_wdata[7:0]), .irq(irq), .irq_pend(irq_pend), .stat_q(stat_q),
  .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_data(pkt_data),
  .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_dma(xfer_dma), .xfer_len(xfer_len)
);

// File: tb/atapi_taskfile_ctrl_bench.sv
`timescale 1ns/1ps
module atapi_taskfile_ctrl_bench;
  localparam int LEN_W = 16;
  localparam int PKTW  = 6;
  localparam logic [3:0] R_DATA = 4'd0, R_ERR = 4'd1, R_RSN = 4'd2, R_SECT = 4'd3,
                         R_BCL = 4'd4, R_BCH = 4'd5, R_STAT = 4'd7, R_ALT = 4'd14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hst_wr = 1'b0, hst_rd = 1'b0;
  logic [3:0] hst_addr = '0;
  logic [15:0] hst_wdata = '0;
  logic [15:0] hst_rdata;
  logic irq;
  logic [LEN_W-2:0] buf_addr;
  logic buf_we;
  logic [15:0] buf_wdata, buf_rdata;
  logic pkt_valid, pkt_ready = 1'b0;
  logic [16*PKTW-1:0] pkt_data;
  logic xfer_valid = 1'b0, xfer_ready, xfer_write = 1'b0, xfer_dma = 1'b0;
  logic [LEN_W-1:0] xfer_len = '0;
  logic dma_done = 1'b0;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [15:0] rv;
  logic cap_we, cap_ready;
  logic [LEN_W-2:0] cap_addr;
  logic [15:0] cap_wdata;
  logic [16*PKTW-1:0] exp_pkt;

  always #2.5 clk = ~clk;

  // back-end buffer model: word at address a reads as 0xA500 | a
  assign buf_rdata = 16'hA500 | 16'(buf_addr);

  atapi_taskfile_ctrl #(.LEN_W(LEN_W), .PKT_WORDS(PKTW)) u_atapi_taskfile_ctrl (
    .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_rd(hst_rd), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .irq(irq),
    .buf_addr(buf_addr), .buf_we(buf_we), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
    .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_data(pkt_data),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_write(xfer_write),
    .xfer_dma(xfer_dma), .xfer_len(xfer_len), .dma_done(dma_done)
  );

  // {feature, command, expected status, expected error, expected irq}
  // R11 set-features, R12 unknown/reset, R2 packet, R10 abort
  localparam logic [39:0] VEC [9] = '{
    {8'h00, 8'hEF, 8'h50, 8'h00, 8'h01},
    {8'h00, 8'h55, 8'h50, 8'h00, 8'h00},
    {8'h03, 8'hA0, 8'h58, 8'h03, 8'h00},
    {8'h00, 8'h00, 8'h51, 8'h04, 8'h01},
    {8'h02, 8'hA0, 8'h58, 8'h02, 8'h00},
    {8'h00, 8'h00, 8'h51, 8'h04, 8'h01},
    {8'h00, 8'h08, 8'h00, 8'h01, 8'h00},
    {8'h01, 8'hA0, 8'h58, 8'h01, 8'h00},
    {8'h00, 8'h08, 8'h00, 8'h01, 8'h00}
  };

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic hw(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    hst_wr = 1'b1; hst_addr = a; hst_wdata = d;
    #1;
    cap_we = buf_we; cap_addr = buf_addr; cap_wdata = buf_wdata;
    @(negedge clk);
    hst_wr = 1'b0;
  endtask

  task automatic hr(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    hst_rd = 1'b1; hst_addr = a;
    #1;
    d = hst_rdata;
    @(negedge clk);
    hst_rd = 1'b0;
  endtask

  task automatic xfer(input logic w, input logic dm, input logic [15:0] n);
    @(negedge clk);
    xfer_valid = 1'b1; xfer_write = w; xfer_dma = dm; xfer_len = n;
    #1;
    cap_ready = xfer_ready;
    @(negedge clk);
    xfer_valid = 1'b0;
  endtask

  task automatic rchk(input string what, input logic [3:0] a, input logic [15:0] e);
    logic [15:0] d;
    hr(a, d);
    chk(what, 32'(d), 32'(e));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    chk("R1 irq", 32'(irq), 0);
    chk("R1 pkt_valid", 32'(pkt_valid), 0);
    rchk("R1 error", R_ERR, 16'h01);
    rchk("R1 reason", R_RSN, 16'h01);
    rchk("R1 sector", R_SECT, 16'h81);
    rchk("R1 bcl", R_BCL, 16'h14);
    rchk("R1 bch", R_BCH, 16'hEB);
    rchk("R1 status", R_ALT, 16'h00);

    // command table
    for (int i = 0; i < 9; i++) begin
      hw(R_ERR, {8'h00, VEC[i][39:32]});
      hw(R_STAT, {8'h00, VEC[i][31:24]});
      chk($sformatf("R2/R10/R11/R12 vec%0d irq", i), 32'(irq), 32'(VEC[i][0]));
      hr(R_ERR, rv);
      chk($sformatf("R2/R10/R11/R12 vec%0d error", i), 32'(rv[7:0]), 32'(VEC[i][15:8]));
      hr(R_ALT, rv);
      chk($sformatf("R2/R10/R11/R12 vec%0d status", i), 32'(rv[7:0]), 32'(VEC[i][23:16]));
    end

    // R2/R3 packet collection and stream back-pressure
    hw(R_ERR, 16'h0000);
    hw(R_STAT, 16'h00A0);
    rchk("R2 reason", R_RSN, 16'h01);
    for (int k = 0; k < PKTW; k++) begin
      exp_pkt[k*16 +: 16] = 16'h1100 + 16'(k) * 16'h0101;
      if (k == PKTW - 1) chk("R3 valid before last word", 32'(pkt_valid), 0);
      hw(R_DATA, 16'h1100 + 16'(k) * 16'h0101);
    end
    chk("R3 pkt_valid", 32'(pkt_valid), 1);
    chk("R3 pkt_data", 32'(pkt_data == exp_pkt), 1);
    rchk("R3 status busy", R_ALT, 16'hD0);
    chk("R2 no irq", 32'(irq), 0);
    repeat (2) @(negedge clk);
    chk("R3 valid held", 32'(pkt_valid), 1);
    chk("R4 ready low with packet waiting", 32'(xfer_ready), 0);
    rchk("R7 data read in busy", R_DATA, 16'hFFFF);
    rchk("R7 status unchanged", R_ALT, 16'hD0);
    pkt_ready = 1'b1;
    @(negedge clk);
    pkt_ready = 1'b0;
    chk("R3 valid drops after ready", 32'(pkt_valid), 0);

    // R4/R6 PIO read of 6 bytes
    xfer(1'b0, 1'b0, 16'd6);
    chk("R4 accepted", 32'(cap_ready), 1);
    chk("R4 irq", 32'(irq), 1);
    rchk("R4 status", R_ALT, 16'h58);
    rchk("R4 bcl", R_BCL, 16'h06);
    rchk("R4 bch", R_BCH, 16'h00);
    rchk("R4 reason read", R_RSN, 16'h02);
    chk("R4 ready low in PIO", 32'(xfer_ready), 0);
    for (int k = 0; k < 3; k++)
      rchk($sformatf("R6 read word %0d", k), R_DATA, 16'hA500 | 16'(k));
    rchk("R6 done status", R_ALT, 16'h50);
    rchk("R6 done reason", R_RSN, 16'h03);
    chk("R6 done irq", 32'(irq), 1);
    rchk("R7 read after done", R_DATA, 16'hFFFF);

    // R8 busy status read keeps pending; R5 dma completion
    xfer(1'b0, 1'b1, 16'h0200);
    rchk("R8 status read while busy", R_STAT, 16'hD0);
    chk("R8 pending kept while busy", 32'(irq), 1);
    @(negedge clk); dma_done = 1'b1; @(negedge clk); dma_done = 1'b0;
    rchk("R5 dma done status", R_ALT, 16'h50);
    rchk("R5 dma done reason", R_RSN, 16'h03);
    chk("R5 dma done irq", 32'(irq), 1);
    rchk("R8 status read idle", R_STAT, 16'h50);
    chk("R8 cleared", 32'(irq), 0);

    // R5 DMA start is quiet
    xfer(1'b1, 1'b1, 16'd8);
    chk("R5 no irq at start", 32'(irq), 0);
    rchk("R5 status", R_ALT, 16'hD0);
    rchk("R5 reason write", R_RSN, 16'h00);
    rchk("R7 read in dma", R_DATA, 16'hFFFF);
    @(negedge clk); dma_done = 1'b1; @(negedge clk); dma_done = 1'b0;

    // R9 mask, R8 alternate status
    hw(R_ALT, 16'h0002);
    chk("R9 masked", 32'(irq), 0);
    hw(R_ALT, 16'h0000);
    chk("R9 unmasked", 32'(irq), 1);
    rchk("R8 alt read", R_ALT, 16'h50);
    chk("R8 alt keeps pending", 32'(irq), 1);
    rchk("R8 clear", R_STAT, 16'h50);

    // R4/R6 PIO write of 4 bytes
    xfer(1'b1, 1'b0, 16'd4);
    rchk("R4 write status", R_ALT, 16'h58);
    rchk("R4 write reason", R_RSN, 16'h00);
    rchk("R4 write bcl", R_BCL, 16'h04);
    rchk("R8 clear in PIO", R_STAT, 16'h58);
    chk("R8 cleared in PIO", 32'(irq), 0);
    hw(R_DATA, 16'hBEEF);
    chk("R6 we0", 32'(cap_we), 1);
    chk("R6 addr0", 32'(cap_addr), 0);
    chk("R6 wdata0", 32'(cap_wdata), 32'h0000BEEF);
    hw(R_DATA, 16'hCAFE);
    chk("R6 addr1", 32'(cap_addr), 1);
    rchk("R6 write done status", R_ALT, 16'h50);
    rchk("R6 write done reason", R_RSN, 16'h03);
    chk("R6 write done irq", 32'(irq), 1);

    // R13 zero-length request
    rchk("R13 pre clear", R_STAT, 16'h50);
    xfer(1'b0, 1'b0, 16'd0);
    chk("R13 irq", 32'(irq), 1);
    rchk("R13 status", R_ALT, 16'h50);
    rchk("R13 reason", R_RSN, 16'h03);
    chk("R13 ready again", 32'(xfer_ready), 1);

    // R6 odd length
    xfer(1'b0, 1'b0, 16'd3);
    rchk("R6 odd first", R_DATA, 16'hA500);
    rchk("R6 odd mid status", R_ALT, 16'h58);
    rchk("R6 odd second", R_DATA, 16'hA501);
    rchk("R6 odd done", R_ALT, 16'h50);

    // R10 abort in mid transfer, R11 byte-count clear, R12 reset command
    xfer(1'b0, 1'b0, 16'd8);
    rchk("R10 pre word", R_DATA, 16'hA500);
    hw(R_STAT, 16'h0000);
    rchk("R10 abort status", R_ALT, 16'h51);
    rchk("R10 abort error", R_ERR, 16'h04);
    rchk("R7 read after abort", R_DATA, 16'hFFFF);
    hw(R_STAT, 16'h00EF);
    rchk("R11 bcl", R_BCL, 16'h00);
    rchk("R11 bch", R_BCH, 16'h00);
    hw(R_STAT, 16'h0008);
    rchk("R12 sector", R_SECT, 16'h81);
    rchk("R12 bcl", R_BCL, 16'h14);
    rchk("R12 bch", R_BCH, 16'hEB);
    rchk("R12 reason", R_RSN, 16'h01);
    chk("R12 irq", 32'(irq), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule